// File: doc/BRIEF.md
# Two-Address I2C Register Target

This block is an I2C target that gives a controller indirect access to a small register file. It answers on two neighbouring 7-bit bus addresses. The upper six address bits come from strap inputs. The lowest address bit chooses between two windows:

- a 3-bit index register (the pointer window);
- a data port that reaches whichever register the index selects.

Accessing a register is a two-step operation. The controller first writes the wanted register number through the pointer window. It then reads or writes through the data window.

The register file holds eight slots:

- Slots 0 to 3 are configuration bytes. They can be read and written, and their contents are exported to the rest of the chip.
- Slot 4 is a status byte: the loss-of-lock event count.
- Slot 5 is a status byte that packs three 2-bit state copies and two mode pins.
- Slots 6 and 7 are unused.

The block runs entirely on a system clock that is much faster than SCL. Both bus lines are resynchronised, and any change shorter than a set number of samples is rejected. START and STOP are then decoded from the cleaned lines, and the bit-level protocol runs from the edges of the cleaned SCL. The target never stretches SCL. It drives SDA only low, through an output enable.

Top module: `i2c_ptr_regfile`

## Requirements
- R1: The target acknowledges an address byte whose upper six bits equal `dev_addr_i`. Bit 1 of that address byte selects the pointer window (0) or the data window (1), and bit 0 is the read flag. Any other address gets no acknowledge, and SDA stays released for the rest of that transfer.
- R2: A byte written through the pointer window sets the 3-bit pointer to its low three bits. A read through the pointer window returns the pointer in bits 2:0, with bits 7:3 zero.
- R3: A read through the data window returns the register that the pointer selects. The pointer does not advance, so every byte of a multi-byte read returns that same register.
- R4: A byte written through the data window while the pointer is 0 to 3 replaces that configuration byte. Configuration byte n appears on `cfg_o[8n+7:8n]`.
- R5: After reset, configuration bytes 0 to 3 hold 0x33, 0x1F, 0x10 and 0x20, the pointer is 0, and SDA is released.
- R6: Data-window writes while the pointer is 4 to 7 change no register, but the target still acknowledges them.
- R7: Register 4 reads `lol_count_i`. Register 5 reads `{lock_state_i[5:0], proto_mode_i, width_mode_i}`, with the state copies in bits 7:2, the protocol-mode pin in bit 1 and the width-mode pin in bit 0.
- R8: Registers 6 and 7 read 0x00.
- R9: Each written byte is acknowledged. During a read, SDA is released for the ninth clock of every byte. After an acknowledge the next byte follows; after a not-acknowledge the target drives nothing until the next START.
- R10: A START seen at any point, including a repeated START without a STOP, restarts address reception.
- R11: A change on SCL or SDA that lasts fewer than `FILT_LEN` system-clock samples is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| dev_addr_i | input | 6 | Strap bits that form bus address bits 7:2 |
| lol_count_i | input | 8 | Loss-of-lock event count (register 4) |
| lock_state_i | input | 6 | Three 2-bit state copies (register 5 bits 7:2) |
| proto_mode_i | input | 1 | Protocol-mode pin (register 5 bit 1) |
| width_mode_i | input | 1 | Width-mode pin (register 5 bit 0) |
| cfg_o | output | 32 | Configuration bytes 0 to 3, byte n at bits 8n+7:8n |

## Verification
The bench builds the block with `FILT_LEN` = 3 and a bus quarter-period of ten system clocks. The quarter-period is long enough to cover the synchroniser and filter delay. It is also short enough that a one-sample SCL pulse placed in the middle of a data byte would shift the bit count if the filter were absent. The strap value 110001 is used for the target's own address. The neighbouring address, with the lowest strap bit inverted, is used to show that the target stays silent for an address that is not its own. The status inputs are held at distinct non-zero patterns, so a swapped field in register 5 shows up in the read data.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int REG_W    = 8;
  localparam int PTR_W    = 3;
  localparam int NUM_CFG  = 4;
  localparam int ADDR_W   = 7;
  localparam int STRAP_W  = ADDR_W - 1;
  localparam int STAT_W   = 2 * 3;
  localparam int BIT_CW   = $clog2(REG_W + 1);

  localparam logic [REG_W-1:0] CFG_RST [NUM_CFG] = '{8'h33, 8'h1F, 8'h10, 8'h20};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;
endpackage

// File: rtl/i2c_rf_filt.sv
module i2c_rf_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  // filtered level follows only after FILT_LEN equal differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // R11: the filtered level flips only after the synchronised input has differed from it
  p_filt_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q));
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
  import i2c_rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_data_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_sel_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [REG_W-1:0] stat0_i,
  input  logic [REG_W-1:0] stat1_i,
  output logic [NUM_CFG*REG_W-1:0] cfg_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [REG_W-1:0] cfg_arr [NUM_CFG];
  logic             data_wr;

  assign data_wr = wr_en_i && wr_sel_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (wr_en_i && !wr_sel_data_i) ptr_q <= wr_data_i[PTR_W-1:0];
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [REG_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= CFG_RST[g];
      else if (data_wr && ptr_q == PTR_W'(g)) byte_q <= wr_data_i;
    end
    assign cfg_arr[g] = byte_q;
    assign cfg_o[g*REG_W +: REG_W] = byte_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (!rd_sel_data_i) begin
      rd_data_o[PTR_W-1:0] = ptr_q;
    end else if (32'(ptr_q) < NUM_CFG) begin
      rd_data_o = cfg_arr[ptr_q[$clog2(NUM_CFG)-1:0]];
    end else if (32'(ptr_q) == NUM_CFG) begin
      rd_data_o = stat0_i;
    end else if (32'(ptr_q) == NUM_CFG + 1) begin
      rd_data_o = stat1_i;
    end
  end

  // R2: a pointer-window write lands in the pointer on the next cycle
  p_ptr_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_data_i) |=> (ptr_q == $past(wr_data_i[PTR_W-1:0])));

  // R4: a data-window write to a configuration slot shows on cfg_o
  p_cfg_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && 32'(ptr_q) < NUM_CFG) |=>
      (cfg_o[$past(ptr_q[$clog2(NUM_CFG)-1:0])*REG_W +: REG_W] == $past(wr_data_i)));

  // R6: data-window writes above the configuration slots leave cfg_o alone
  p_status_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && 32'(ptr_q) >= NUM_CFG) |=> $stable(cfg_o));
endmodule

// File: rtl/i2c_rf_target.sv
module i2c_rf_target
  import i2c_rf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] dev_addr_i,
  input  logic [REG_W-1:0]   rd_data_i,
  output logic               wr_en_o,
  output logic [REG_W-1:0]   wr_data_o,
  output logic               sel_data_o,
  output logic               sda_oe_o
);
  bus_st_e           st_q;
  logic              scl_p, sda_p;
  logic [REG_W-1:0]  shreg_q, tx_q, wr_data_q;
  logic [BIT_CW-1:0] cnt_q;
  logic              rnw_q, sel_q, nack_q, wr_en_q;
  logic              scl_rise, scl_fall, start_c, stop_c, byte_done;

  assign scl_rise  = scl_i && !scl_p;
  assign scl_fall  = !scl_i && scl_p;
  assign start_c   = scl_i && scl_p && sda_p && !sda_i;
  assign stop_c    = scl_i && scl_p && !sda_p && sda_i;
  assign byte_done = scl_fall && (cnt_q == BIT_CW'(REG_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
      shreg_q   <= '0;
      tx_q      <= '1;
      wr_data_q <= '0;
      cnt_q     <= '0;
      rnw_q     <= 1'b0;
      sel_q     <= 1'b0;
      nack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      scl_p   <= scl_i;
      sda_p   <= sda_i;
      wr_en_q <= 1'b0;
      if (start_c) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
      end else if (stop_c) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[REG_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (byte_done) begin
              cnt_q <= '0;
              if (shreg_q[REG_W-1:2] == dev_addr_i) begin
                st_q  <= ST_ADDR_ACK;
                rnw_q <= shreg_q[0];
                sel_q <= shreg_q[1];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rnw_q) begin
              tx_q <= rd_data_i;
              st_q <= ST_RD;
            end else begin
              st_q <= ST_WR;
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[REG_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (byte_done) begin
              wr_en_q   <= 1'b1;
              wr_data_q <= shreg_q;
              cnt_q     <= '0;
              st_q      <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: if (scl_fall) st_q <= ST_WR;
          ST_RD: if (scl_fall) begin
            tx_q <= {tx_q[REG_W-2:0], 1'b1};
            if (cnt_q == BIT_CW'(REG_W - 1)) begin
              cnt_q <= '0;
              st_q  <= ST_RD_ACK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_i;
            end else if (scl_fall) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                tx_q <= rd_data_i;
                st_q <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o    = wr_en_q;
  assign wr_data_o  = wr_data_q;
  assign sel_data_o = sel_q;
  assign sda_oe_o   = (st_q == ST_ADDR_ACK) || (st_q == ST_WR_ACK) ||
                      ((st_q == ST_RD) && !tx_q[REG_W-1]);

  // R9: SDA never changes while SCL stays high outside START/STOP
  p_oe_scl_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && scl_p && $past(scl_i) && !start_c && !stop_c && !$past(start_c) && !$past(stop_c))
      |-> $stable(sda_oe_o));

  // R1: a foreign address byte is followed by a released SDA
  p_no_ack_foreign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && byte_done && !start_c && !stop_c &&
     shreg_q[REG_W-1:2] != dev_addr_i) |=> !sda_oe_o);

  // R9: SDA is released during the controller acknowledge slot
  p_rd_ack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_ACK) |-> !sda_oe_o);
endmodule

// File: rtl/i2c_ptr_regfile.sv
module i2c_ptr_regfile
  import i2c_rf_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic [STRAP_W-1:0]       dev_addr_i,
  input  logic [REG_W-1:0]         lol_count_i,
  input  logic [STAT_W-1:0]        lock_state_i,
  input  logic                     proto_mode_i,
  input  logic                     width_mode_i,
  output logic [NUM_CFG*REG_W-1:0] cfg_o
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] line_raw, line_filt;
  logic                 wr_en, sel_data;
  logic [REG_W-1:0]     wr_data, rd_data, stat1;

  assign line_raw = {sda_i, scl_i};
  assign stat1    = {lock_state_i, proto_mode_i, width_mode_i};

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    i2c_rf_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (line_raw[l]),
      .filt_o (line_filt[l])
    );
  end

  i2c_rf_target u_target (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (line_filt[0]),
    .sda_i      (line_filt[1]),
    .dev_addr_i (dev_addr_i),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sel_data_o (sel_data),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_rf_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .wr_sel_data_i (sel_data),
    .wr_data_i     (wr_data),
    .rd_sel_data_i (sel_data),
    .rd_data_o     (rd_data),
    .stat0_i       (lol_count_i),
    .stat1_i       (stat1),
    .cfg_o         (cfg_o)
  );
endmodule

// File: tb/i2c_ptr_regfile_bench.sv
module i2c_ptr_regfile_bench;
  localparam int QP = 10;
  localparam logic [5:0] STRAP = 6'b110001;
  localparam logic [7:0] LOL   = 8'h9C;
  localparam logic [5:0] LSTAT = 6'b100111;
  localparam logic [7:0] STAT1 = 8'h9E;  // {100111,1,0}
  localparam logic [7:0] A_PTR_W  = {STRAP, 2'b00};
  localparam logic [7:0] A_PTR_R  = {STRAP, 2'b01};
  localparam logic [7:0] A_DATA_W = {STRAP, 2'b10};
  localparam logic [7:0] A_DATA_R = {STRAP, 2'b11};

  // {wr, ptr[2:0], data[7:0], exp[7:0], req[3:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 8'h33, 4'd5},   // R5
    {1'b0, 3'd1, 8'h00, 8'h1F, 4'd5},   // R5
    {1'b0, 3'd2, 8'h00, 8'h10, 4'd5},   // R5
    {1'b0, 3'd3, 8'h00, 8'h20, 4'd5},   // R5
    {1'b1, 3'd0, 8'hA5, 8'h00, 4'd4},   // R4
    {1'b0, 3'd0, 8'h00, 8'hA5, 4'd3},   // R3
    {1'b1, 3'd3, 8'h5C, 8'h00, 4'd4},   // R4
    {1'b0, 3'd3, 8'h00, 8'h5C, 4'd3},   // R3
    {1'b1, 3'd4, 8'hFF, 8'h00, 4'd6},   // R6
    {1'b0, 3'd4, 8'h00, LOL,   4'd7},   // R7
    {1'b1, 3'd5, 8'h00, 8'h00, 4'd6},   // R6
    {1'b0, 3'd5, 8'h00, STAT1, 4'd7},   // R7
    {1'b1, 3'd7, 8'hAA, 8'h00, 4'd6},   // R6
    {1'b0, 3'd6, 8'h00, 8'h00, 4'd8}    // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [31:0] cfg;
  logic [31:0] cfg_model = 32'h2010_1F33;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_ptr_regfile #(.FILT_LEN(3)) u_i2c_ptr_regfile (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .dev_addr_i   (STRAP),
    .lol_count_i  (LOL),
    .lock_state_i (LSTAT),
    .proto_mode_i (1'b1),
    .width_mode_i (1'b0),
    .cfg_o        (cfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic qp(); repeat (QP) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qp(); scl = 1'b1; qp(); sda_m = 1'b0; qp(); scl = 1'b0; qp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qp(); scl = 1'b1; qp(); sda_m = 1'b1; qp();
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_m = b; qp(); scl = 1'b1; qp(); qp(); scl = 1'b0;
    if (glitch) begin
      repeat (3) @(negedge clk);
      scl = 1'b1; @(negedge clk); scl = 1'b0;
      repeat (QP - 4) @(negedge clk);
    end else begin
      qp();
    end
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qp(); scl = 1'b1; qp(); b = sda_line; qp(); scl = 1'b0; qp();
  endtask

  task automatic put_byte(input logic [7:0] d, input bit glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch && i == 4);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack_it);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~ack_it, 1'b0);
  endtask

  task automatic set_ptr(input logic [2:0] p);
    logic a;
    bus_start(); put_byte(A_PTR_W, 1'b0, a); put_byte({5'b0, p}, 1'b0, a); bus_stop();
  endtask

  task automatic wr_reg(input logic [2:0] p, input logic [7:0] d);
    logic a;
    set_ptr(p);
    bus_start(); put_byte(A_DATA_W, 1'b0, a);
    put_byte(d, 1'b0, a); bus_stop();
    check("R9 data byte ack", {31'b0, a}, 32'd1);
  endtask

  task automatic rd_reg(input logic [2:0] p, output logic [7:0] d);
    logic a;
    set_ptr(p);
    bus_start(); put_byte(A_DATA_R, 1'b0, a); get_byte(d, 1'b0); bus_stop();
  endtask

  initial begin
    logic [7:0] d, d2;
    logic       a, b;
    repeat (5) @(negedge clk);
    check("R5 reset sda released", {31'b0, sda_oe}, 32'd0);
    check("R5 reset cfg", cfg, 32'h2010_1F33);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v = VEC[i];
      string rq = $sformatf("R%0d vec %0d", v[3:0], i);
      if (v[23]) begin
        wr_reg(v[22:20], v[19:12]);
        if (v[22:20] < 3'd4) cfg_model[v[22:20]*8 +: 8] = v[19:12];
        check(rq, cfg, cfg_model);
      end else begin
        rd_reg(v[22:20], d);
        check(rq, {24'b0, d}, {24'b0, v[11:4]});
      end
    end

    // R2: pointer readback
    set_ptr(3'd5);
    bus_start(); put_byte(A_PTR_R, 1'b0, a); get_byte(d, 1'b0); bus_stop();
    check("R2 pointer readback", {24'b0, d}, 32'h05);

    // R1: foreign address not acknowledged, own pointer address acknowledged
    bus_start(); put_byte({STRAP ^ 6'b000001, 2'b10}, 1'b0, a);
    check("R1 foreign address", {31'b0, a}, 32'd0);
    put_byte(8'h77, 1'b0, a);
    check("R1 silent after foreign address", {31'b0, a}, 32'd0);
    bus_stop();
    check("R1 foreign write no effect", cfg, cfg_model);
    bus_start(); put_byte(A_PTR_W, 1'b0, a); bus_stop();
    check("R1 own address ack", {31'b0, a}, 32'd1);

    // R3/R9: multi-byte read repeats the same register, release after NACK
    set_ptr(3'd1);
    bus_start(); put_byte(A_DATA_R, 1'b0, a);
    get_byte(d, 1'b1); get_byte(d2, 1'b0);
    get_bit(b);
    check("R9 released after NACK", {31'b0, b}, 32'd1);
    bus_stop();
    check("R3 first byte", {24'b0, d}, 32'h1F);
    check("R3 no auto increment", {24'b0, d2}, 32'h1F);

    // R9/R4: two written bytes both acknowledged, last one stays
    set_ptr(3'd1);
    bus_start(); put_byte(A_DATA_W, 1'b0, a);
    put_byte(8'h11, 1'b0, a); put_byte(8'hC3, 1'b0, b); bus_stop();
    check("R9 second byte ack", {30'b0, a, b}, 32'd3);
    cfg_model[15:8] = 8'hC3;
    check("R4 multi-byte write", cfg, cfg_model);

    // R10: repeated START between pointer write and data read
    bus_start(); put_byte(A_PTR_W, 1'b0, a); put_byte(8'h02, 1'b0, a);
    bus_start(); put_byte(A_DATA_R, 1'b0, a); get_byte(d, 1'b0); bus_stop();
    check("R10 repeated start read", {24'b0, d}, 32'h10);

    // R11: one-sample SCL glitch inside a data byte is filtered
    set_ptr(3'd2);
    bus_start(); put_byte(A_DATA_W, 1'b0, a); put_byte(8'h6B, 1'b1, a); bus_stop();
    cfg_model[23:16] = 8'h6B;
    check("R11 glitch filtered", cfg, cfg_model);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule